// File: doc/BRIEF.md
# GPIO Port with Interrupt Sensing

A 32-pin general-purpose I/O port controlled through a small word-addressed register bus. Each pin is set as an input or an output. Output pins drive the value software writes. Input pins are sampled into a pad register once per clock.

Every input pin can raise an interrupt status bit. The trigger is a per-pin two-bit mode: low level, high level, rising edge or falling edge. A per-pin both-edges bit can override that mode. Status bits are cleared by writing 1 to them. Level conditions that still hold set their bit again at once. Masked status drives one interrupt line, or two lines that each cover half of the pins.

A parameter decides whether the both-edges register exists. A second parameter decides whether the interrupt output is split into two lines.

Top module: `gpio_port`

## Requirements
- R1: Reset clears every register to 0. After reset all pins are inputs, all interrupts are masked and both interrupt lines are low.
- R2: Read data appears on `rdData` one cycle after `rdEn` and holds until the next read. The word addresses are: 0 output data, 1 direction, 2 pad status, 3 mode of pins 0..15, 4 mode of pins 16..31, 5 mask, 6 status, 7 both-edges.
- R3: A direction bit of 1 makes its pin an output. `pinOe` is then 1 and `pinOut` carries the output data bit. For input pins, `pinOut` is 0.
- R4: Reading word 0 returns the output data bit for output pins and the sampled pad level for input pins. Reading word 2 returns the sampled pad levels with output-pin bits forced to 0.
- R5: Pin n's mode is at bits 2n+1:2n of the 64-bit value {word 4, word 3}. Mode 00 sets status while the pin is low, and mode 01 sets it while the pin is high.
- R6: Mode 10 sets status on a rising edge and mode 11 on a falling edge. An edge is found by comparing the pad sample with the previous cycle's sample.
- R7: A both-edges bit of 1 overrides the pin's mode, and any level change sets status. With the register absent, word 7 reads 0 and writes to it have no effect.
- R8: Writing status clears each bit written as 1 and keeps the others. A detection in the same cycle wins over the clear, so a level condition that still holds stays set.
- R9: Pins set as outputs never set status bits.
- R10: With the split off, line 0 is the OR of status AND mask over all pins and line 1 stays 0. With the split on, line 0 covers pins 15:0 and line 1 covers pins 31:16.
- R11: Unmapped word addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 4 | Word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, registered |
| pinIn | input | 32 | Pin input levels |
| pinOut | output | 32 | Pin output levels |
| pinOe | output | 32 | Pin output enables |
| irq | output | 2 | Interrupt request lines |

## Verification
The bench builds two copies of the block that share one bus and one set of pins. The first copy has the both-edges register and split interrupt lines. The second has neither register nor split.

Because both copies see the same stimulus, every read can compare the override against plain rising-edge sensing. It also shows that the absent register reads 0 and ignores writes. The same setup shows how one masked pin in each half maps onto one line or onto two.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Word addresses of the register file
  localparam int REG_DATA  = 0;
  localparam int REG_DIR   = 1;
  localparam int REG_PAD   = 2;
  localparam int REG_CFGLO = 3;
  localparam int REG_CFGHI = 4;
  localparam int REG_MASK  = 5;
  localparam int REG_STAT  = 6;
  localparam int REG_BOTH  = 7;
  localparam int NUM_REGS  = 8;
  localparam int SEL_W     = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic             wrData;
    logic             wrDir;
    logic             wrCfgLo;
    logic             wrCfgHi;
    logic             wrMask;
    logic             wrStat;
    logic             wrBoth;
    logic             rdEn;
    logic             hit;
    logic [SEL_W-1:0] rdSel;
  } strobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output strobe_t           strb,
  output logic [DATA_W-1:0] clrMask
);

  logic             hit;
  logic [SEL_W-1:0] sel;

  assign hit = (addr < ADDR_W'(NUM_REGS));
  assign sel = addr[SEL_W-1:0];

  always_comb begin
    strb       = '0;
    strb.rdEn  = rdEn;
    strb.hit   = hit;
    strb.rdSel = sel;
    if (wrEn && hit) begin
      unique case (sel)
        SEL_W'(REG_DATA):  strb.wrData  = 1'b1;
        SEL_W'(REG_DIR):   strb.wrDir   = 1'b1;
        SEL_W'(REG_CFGLO): strb.wrCfgLo = 1'b1;
        SEL_W'(REG_CFGHI): strb.wrCfgHi = 1'b1;
        SEL_W'(REG_MASK):  strb.wrMask  = 1'b1;
        SEL_W'(REG_STAT):  strb.wrStat  = 1'b1;
        SEL_W'(REG_BOTH):  strb.wrBoth  = 1'b1;
        default: ;
      endcase
    end
  end

  // Write-one-to-clear mask for the status register
  assign clrMask = strb.wrStat ? wrData : '0;

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter bit HAS_BOTH_EDGE = 1'b1,
  parameter bit SPLIT_IRQ     = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] clrMask,
  input  logic [DATA_W-1:0] pinIn,
  output logic [DATA_W-1:0] pinOut,
  output logic [DATA_W-1:0] pinOe,
  output logic [1:0]        irq,
  output logic [DATA_W-1:0] rdData
);

  localparam int HALF  = DATA_W / 2;
  localparam int CFG_W = 2 * DATA_W;

  logic [DATA_W-1:0] outData;
  logic [DATA_W-1:0] dirReg;
  logic [DATA_W-1:0] padSamp;
  logic [DATA_W-1:0] padPrev;
  logic [CFG_W-1:0]  modeCfg;
  logic [DATA_W-1:0] maskReg;
  logic [DATA_W-1:0] statReg;
  logic [DATA_W-1:0] bothEdge;
  logic [DATA_W-1:0] detHit;
  logic [DATA_W-1:0] pend;
  logic [DATA_W-1:0] rdNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      outData <= '0;
      dirReg  <= '0;
      padSamp <= '0;
      padPrev <= '0;
      modeCfg <= '0;
      maskReg <= '0;
      statReg <= '0;
    end else begin
      padSamp <= pinIn;
      padPrev <= padSamp;
      if (strb.wrData)  outData <= wrData;
      if (strb.wrDir)   dirReg  <= wrData;
      if (strb.wrCfgLo) modeCfg[DATA_W-1:0] <= wrData;
      if (strb.wrCfgHi) modeCfg[CFG_W-1:DATA_W] <= wrData;
      if (strb.wrMask)  maskReg <= wrData;
      // a detection in this cycle overrides a clear
      statReg <= (statReg & ~clrMask) | detHit;
    end
  end

  // Optional both-edges register
  generate
    if (HAS_BOTH_EDGE) begin : g_both
      always_ff @(posedge clk) begin
        if (rst)              bothEdge <= '0;
        else if (strb.wrBoth) bothEdge <= wrData;
      end
    end else begin : g_noBoth
      assign bothEdge = '0;
    end
  endgenerate

  // Per-pin trigger detection
  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_det
      logic [1:0] mode;
      logic       changed;
      assign mode    = modeCfg[2*i +: 2];
      assign changed = padSamp[i] ^ padPrev[i];
      always_comb begin
        if (dirReg[i])       detHit[i] = 1'b0;
        else if (bothEdge[i]) detHit[i] = changed;
        else if (mode[1])    detHit[i] = changed & (padSamp[i] != mode[0]);
        else                 detHit[i] = (padSamp[i] == mode[0]);
      end
    end
  endgenerate

  // Interrupt lines
  assign pend = statReg & maskReg;
  generate
    if (SPLIT_IRQ) begin : g_split
      assign irq[0] = |pend[HALF-1:0];
      assign irq[1] = |pend[DATA_W-1:HALF];
    end else begin : g_single
      assign irq[0] = |pend;
      assign irq[1] = 1'b0;
    end
  endgenerate

  // Pins
  assign pinOe  = dirReg;
  assign pinOut = outData & dirReg;

  // Read path
  always_comb begin
    unique case (strb.rdSel)
      SEL_W'(REG_DATA):  rdNext = (outData & dirReg) | (padSamp & ~dirReg);
      SEL_W'(REG_DIR):   rdNext = dirReg;
      SEL_W'(REG_PAD):   rdNext = padSamp & ~dirReg;
      SEL_W'(REG_CFGLO): rdNext = modeCfg[DATA_W-1:0];
      SEL_W'(REG_CFGHI): rdNext = modeCfg[CFG_W-1:DATA_W];
      SEL_W'(REG_MASK):  rdNext = maskReg;
      SEL_W'(REG_STAT):  rdNext = statReg;
      default:           rdNext = bothEdge;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            rdData <= '0;
    else if (strb.rdEn) rdData <= strb.hit ? rdNext : '0;
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int DATA_W        = 32,
  parameter bit HAS_BOTH_EDGE = 1'b1,
  parameter bit SPLIT_IRQ     = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] pinIn,
  output logic [DATA_W-1:0] pinOut,
  output logic [DATA_W-1:0] pinOe,
  output logic [1:0]        irq
);

  strobe_t           strb;
  logic [DATA_W-1:0] clrMask;

  gpio_port_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .strb(strb), .clrMask(clrMask)
  );

  gpio_port_dp #(
    .DATA_W(DATA_W), .HAS_BOTH_EDGE(HAS_BOTH_EDGE), .SPLIT_IRQ(SPLIT_IRQ)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .wrData(wrData), .clrMask(clrMask),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irq(irq), .rdData(rdData)
  );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              rdEn,
  input logic [DATA_W-1:0] rdData,
  input logic [DATA_W-1:0] pinOut,
  input logic [DATA_W-1:0] pinOe,
  input logic [1:0]        irq,
  input logic [DATA_W-1:0] statReg,
  input logic [DATA_W-1:0] dirReg,
  input logic [DATA_W-1:0] maskReg,
  input logic [DATA_W-1:0] outData,
  input logic [DATA_W-1:0] clrMask,
  input logic              wrUnmapped
);

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (statReg == '0 && dirReg == '0 && maskReg == '0 && irq == 2'b00));

  a_r2_read_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(rdEn) |-> $stable(rdData));

  a_r3_input_quiet: assert property (@(posedge clk) disable iff (rst)
    (pinOut & ~pinOe) == '0);

  a_r8_sticky_status: assert property (@(posedge clk) disable iff (rst)
    (~statReg & $past(statReg) & ~$past(clrMask)) == '0);

  a_r9_output_no_status: assert property (@(posedge clk) disable iff (rst)
    (statReg & ~$past(statReg) & $past(dirReg)) == '0);

  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (maskReg == '0) |-> (irq == 2'b00));

  a_r11_unmapped_write: assert property (@(posedge clk) disable iff (rst)
    $past(wrUnmapped) |-> ($stable(outData) && $stable(dirReg) && $stable(maskReg)));

endmodule

bind gpio_port gpio_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rdEn(rdEn), .rdData(rdData),
  .pinOut(pinOut), .pinOe(pinOe), .irq(irq),
  .statReg(u_dp.statReg), .dirReg(u_dp.dirReg), .maskReg(u_dp.maskReg),
  .outData(u_dp.outData), .clrMask(clrMask), .wrUnmapped(wrEn && !strb.hit)
);

// File: tb/sim_gpio_port.sv
module sim_gpio_port;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] pinIn = '0;
  logic [DW-1:0] rd0, rd1, po0, po1, oe0, oe1;
  logic [1:0]    irq0, irq1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [DW-1:0] e0;
    logic [DW-1:0] e1;
    string         tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port #(.ADDR_W(AW), .DATA_W(DW), .HAS_BOTH_EDGE(1'b1), .SPLIT_IRQ(1'b1)) u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rd0), .pinIn(pinIn), .pinOut(po0), .pinOe(oe0), .irq(irq0)
  );

  gpio_port #(.ADDR_W(AW), .DATA_W(DW), .HAS_BOTH_EDGE(1'b0), .SPLIT_IRQ(1'b0)) u1 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rd1), .pinIn(pinIn), .pinOut(po1), .pinOe(oe1), .irq(irq1)
  );

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e0,
                    input logic [DW-1:0] e1, input string tag);
    exp_t it;
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    it.e0 = e0; it.e1 = e1; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic setPins(input logic [DW-1:0] d);
    @(negedge clk);
    pinIn = d;
    repeat (3) @(negedge clk);
  endtask

  // Monitor: pops expected read data one cycle after each read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (rdEn) begin
        @(negedge clk);
        if (q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2: read data with no expected item");
        end else begin
          exp_t it;
          it = q.pop_front();
          chk({it.tag, " u0"}, rd0, it.e0);
          chk({it.tag, " u1"}, rd1, it.e1);
        end
      end
    end
  end

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq u0", {30'd0, irq0}, 0);
    chk("R1 irq u1", {30'd0, irq1}, 0);
    chk("R1 pinOe", oe0 | oe1, 0);
    chk("R3 pinOut idle", po0 | po1, 0);
    rd(4'd1, 0, 0, "R1 dir");
    rd(4'd5, 0, 0, "R1 mask");
    rd(4'd3, 0, 0, "R1 cfgLo");
    rd(4'd7, 0, 0, "R1 both");

    // R3 / R4 direction and readback
    wr(4'd1, 32'h0000_00FF);
    wr(4'd0, 32'hA5A5_A5A5);
    setPins(32'h1234_5600);
    chk("R3 pinOut u0", po0, 32'h0000_00A5);
    chk("R3 pinOut u1", po1, 32'h0000_00A5);
    chk("R3 pinOe", oe0, 32'h0000_00FF);
    rd(4'd0, 32'h1234_56A5, 32'h1234_56A5, "R4 data mix");
    setPins(32'h1234_56FF);
    rd(4'd2, 32'h1234_5600, 32'h1234_5600, "R4 pad forced");
    rd(4'd0, 32'h1234_56A5, 32'h1234_56A5, "R4 data mix 2");

    // R5 / R6 / R8 modes
    setPins(32'h0);
    wr(4'd1, 32'h0);
    wr(4'd3, 32'hAAAA_AA39);
    wr(4'd4, 32'hAAAA_AAAA);
    wr(4'd6, 32'hFFFF_FFFF);
    rd(4'd6, 32'h8, 32'h8, "R8 level reassert");
    chk("R10 masked u0", {30'd0, irq0}, 0);
    chk("R10 masked u1", {30'd0, irq1}, 0);
    setPins(32'h1);
    rd(4'd6, 32'h9, 32'h9, "R5 high level");
    setPins(32'h0);
    wr(4'd6, 32'h1);
    rd(4'd6, 32'h8, 32'h8, "R8 clear one");
    setPins(32'h2);
    rd(4'd6, 32'hA, 32'hA, "R6 rising");
    setPins(32'h6);
    rd(4'd6, 32'hA, 32'hA, "R6 falling mode ignores rise");
    wr(4'd6, 32'h2);
    rd(4'd6, 32'h8, 32'h8, "R8 edge no reassert");
    setPins(32'h4);
    rd(4'd6, 32'h8, 32'h8, "R6 rising mode ignores fall");
    setPins(32'h0);
    rd(4'd6, 32'hC, 32'hC, "R6 falling");
    setPins(32'h8);
    wr(4'd6, 32'hF);
    rd(4'd6, 32'h0, 32'h0, "R5 low level released");

    // R7 both edges
    wr(4'd7, 32'h0001_0000);
    setPins(32'h0001_0008);
    rd(4'd6, 32'h0001_0000, 32'h0001_0000, "R7 rise");
    wr(4'd6, 32'h0001_0000);
    rd(4'd6, 32'h0, 32'h0, "R8 clear");
    setPins(32'h8);
    rd(4'd6, 32'h0001_0000, 32'h0, "R7 fall override");
    rd(4'd7, 32'h0001_0000, 32'h0, "R7 register absent");

    // R10 interrupt lines
    wr(4'd5, 32'h0001_0000);
    chk("R10 split high u0", {30'd0, irq0}, 2);
    chk("R10 single u1", {30'd0, irq1}, 0);
    setPins(32'hC);
    setPins(32'h8);
    wr(4'd5, 32'h0001_0004);
    chk("R10 split both u0", {30'd0, irq0}, 3);
    chk("R10 single u1 on", {30'd0, irq1}, 1);
    wr(4'd6, 32'h0001_0000);
    chk("R10 low only u0", {30'd0, irq0}, 1);
    chk("R10 u1 still on", {30'd0, irq1}, 1);
    wr(4'd6, 32'hFFFF_FFFF);
    chk("R10 cleared u0", {30'd0, irq0}, 0);
    chk("R10 cleared u1", {30'd0, irq1}, 0);

    // R9 outputs do not detect
    wr(4'd1, 32'h20);
    setPins(32'h28);
    setPins(32'h8);
    rd(4'd6, 32'h0, 32'h0, "R9 output pin");
    chk("R3 pinOut bit5", po0, 32'h20);
    chk("R3 pinOe bit5", oe1, 32'h20);

    // R11 unmapped
    rd(4'd9, 32'h0, 32'h0, "R11 unmapped read");
    wr(4'd10, 32'hFFFF_FFFF);
    rd(4'd5, 32'h0001_0004, 32'h0001_0004, "R11 mask kept");
    rd(4'd1, 32'h20, 32'h20, "R11 dir kept");
    rd(4'd3, 32'hAAAA_AA39, 32'hAAAA_AA39, "R5 cfgLo read");
    rd(4'd4, 32'hAAAA_AAAA, 32'hAAAA_AAAA, "R5 cfgHi read");
    rd(4'd0, 32'h28, 32'h28, "R11 data kept");

    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2: got %0d pending expected 0", q.size());
    end
    finish();
  end

endmodule